// File: doc/BRIEF.md
# Receive Character Buffer with Line Status

This block sits on the receive side of a serial port register file. A receive shift register, which is outside this block, delivers each finished character as a one-cycle pulse. The pulse carries eight data bits and three flags: parity error, framing error and break. The block keeps these characters in a queue of `DEPTH` entries when queue mode is on. When queue mode is off it keeps them in a single holding slot. Each stored character keeps its own flags.

The host reads the oldest character on `rhr_o` and removes it with a read strobe. The host reads the line status byte on `lsr_o` and acknowledges it with a separate read strobe. The error bits in the status byte describe only the character at the head of the queue. An overrun throws away the arriving character and leaves the stored ones untouched. Reading the status byte clears its error bits. A line-status interrupt request is raised while any error bit is set. For test purposes, a write strobe can load the error bits.

Top module: `rx_char_buffer`

## Requirements
- R1: After reset the queue is empty, `lsr_o` reads 0x60 and `rls_irq_o` is low.
- R2: Status bit 0 (data ready) is high exactly while at least one character is stored. It rises on the clock edge that accepts a character. `rhr_o` shows the oldest stored character. A pulse on `rhr_rd_i` removes that character at the edge, so characters leave in arrival order.
- R3: Capacity is `DEPTH` (default 16) characters when `fifo_en_i` is 1 and one character when it is 0.
- R4: A character that arrives while the occupancy at the start of that cycle equals the capacity is discarded, even if a read happens in the same cycle. The discard sets status bit 1 (overrun) and leaves the stored characters unchanged.
- R5: Status bits 2, 3 and 4 show the parity, framing and break flags of the head character only. Flags of characters behind the head do not appear.
- R6: A pulse on `lsr_rd_i` clears bits 1 to 4 from the next cycle. Bits 2 to 4 then stay clear until a different character reaches the head. An overrun in the same cycle as the read leaves bit 1 set.
- R7: Status bit 7 is high while any stored character carries a parity, framing or break flag. Once no such character remains, bit 7 stays high until the next `lsr_rd_i`.
- R8: Status bits 5 and 6 always read 1.
- R9: `rls_irq_o` is high exactly when any of status bits 1 to 4 is high.
- R10: A pulse on `lsr_wr_i` loads bit 1 from `lsr_wdata_i[1]` and forces bits 2 to 4 high where `lsr_wdata_i[4:2]` is 1. The forced bits hold until the next `lsr_rd_i`. Bits 0, 5, 6 and 7 ignore the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 selects queue mode, 0 selects the single holding slot |
| rx_valid_i | input | 1 | One-cycle pulse: a received character is ready |
| rx_data_i | input | 8 | Received character |
| rx_perr_i | input | 1 | Parity error flag of the character |
| rx_ferr_i | input | 1 | Framing error flag of the character |
| rx_brk_i | input | 1 | Break flag of the character |
| rhr_rd_i | input | 1 | Host read strobe for the holding register |
| lsr_rd_i | input | 1 | Host read strobe for the status byte |
| lsr_wr_i | input | 1 | Test write strobe for the status byte |
| lsr_wdata_i | input | 8 | Test write data |
| rhr_o | output | 8 | Oldest stored character |
| lsr_o | output | 8 | Line status byte |
| rls_irq_o | output | 1 | Receiver line-status interrupt request |

## Verification
Every result becomes visible after exactly one clock edge following its stimulus. `rhr_o` and `lsr_o` come only from registers, and `rls_irq_o` is a function of `lsr_o` with no further delay. The bench applies each step's inputs on a falling edge and lets one rising edge pass. It compares the outputs on the following falling edge, then clears the strobes before the next step. Same-cycle collisions are driven deliberately: a read together with an arrival, and an overrun together with a read. These expose any off-by-one-cycle ordering.

// File: rtl/rx_buf_pkg.sv
package rx_buf_pkg;
  localparam int DW = 8;

  typedef struct packed {
    logic          brk;
    logic          ferr;
    logic          perr;
    logic [DW-1:0] data;
  } rx_ent_t;
endpackage

// File: rtl/rx_store.sv
module rx_store
  import rx_buf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    fifo_en_i,
  input  logic    wr_i,
  input  rx_ent_t wdata_i,
  input  logic    rd_i,
  output rx_ent_t head_o,
  output logic    not_empty_o,
  output logic    push_o,
  output logic    pop_o,
  output logic    ovr_o,
  output logic    err_any_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CAP_Q = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_1 = CW'(1);

  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q, cnt_err_q;
  logic [CW-1:0] cap;
  logic          full, ent_err, head_err;
  rx_ent_t       slot_q [DEPTH];

  assign cap      = fifo_en_i ? CAP_Q : CAP_1;
  // full is judged on the occupancy before this cycle's read
  assign full     = (cnt_q >= cap);
  assign push_o   = wr_i & ~full;
  assign ovr_o    = wr_i & full;
  assign pop_o    = rd_i & (cnt_q != '0);
  assign ent_err  = wdata_i.perr | wdata_i.ferr | wdata_i.brk;
  assign head_o   = slot_q[rd_ptr_q];
  assign head_err = head_o.perr | head_o.ferr | head_o.brk;
  assign not_empty_o = (cnt_q != '0);
  assign err_any_o   = (cnt_err_q != '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        slot_q[i] <= '0;
      else if (push_o && (wr_ptr_q == PW'(i)))
        slot_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      cnt_q     <= '0;
      cnt_err_q <= '0;
    end else begin
      if (push_o) wr_ptr_q <= (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop_o)  rd_ptr_q <= (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      cnt_q     <= cnt_q + CW'(push_o) - CW'(pop_o);
      cnt_err_q <= cnt_err_q + CW'(push_o & ent_err) - CW'(pop_o & head_err);
    end
  end
endmodule

// File: rtl/rx_status.sv
module rx_status
  import rx_buf_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  rx_ent_t head_i,
  input  logic    not_empty_i,
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    ovr_i,
  input  logic    err_any_i,
  input  logic    lsr_rd_i,
  input  logic    lsr_wr_i,
  input  logic [7:0] lsr_wdata_i,
  output logic [7:0] lsr_o,
  output logic    irq_o
);
  logic       ovr_q, hide_q, stale_q;
  logic [2:0] force_q;
  logic [2:0] head_flags;

  // hide_q suppresses head flags already reported by a status read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q   <= 1'b0;
      hide_q  <= 1'b0;
      stale_q <= 1'b0;
      force_q <= '0;
    end else begin
      if (ovr_i)         ovr_q <= 1'b1;
      else if (lsr_wr_i) ovr_q <= lsr_wdata_i[1];
      else if (lsr_rd_i) ovr_q <= 1'b0;

      if (lsr_wr_i)      force_q <= lsr_wdata_i[4:2];
      else if (lsr_rd_i) force_q <= '0;

      if (pop_i || (push_i && !not_empty_i)) hide_q <= 1'b0;
      else if (lsr_rd_i && not_empty_i)      hide_q <= 1'b1;

      if (lsr_rd_i) stale_q <= 1'b0;
      else          stale_q <= stale_q | err_any_i;
    end
  end

  assign head_flags = (not_empty_i && !hide_q) ? {head_i.brk, head_i.ferr, head_i.perr} : 3'b000;

  always_comb begin
    lsr_o      = 8'h60;
    lsr_o[0]   = not_empty_i;
    lsr_o[1]   = ovr_q;
    lsr_o[4:2] = head_flags | force_q;
    lsr_o[7]   = err_any_i | stale_q;
  end

  assign irq_o = |lsr_o[4:1];
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
  import rx_buf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_perr_i,
  input  logic          rx_ferr_i,
  input  logic          rx_brk_i,
  input  logic          rhr_rd_i,
  input  logic          lsr_rd_i,
  input  logic          lsr_wr_i,
  input  logic [7:0]    lsr_wdata_i,
  output logic [DW-1:0] rhr_o,
  output logic [7:0]    lsr_o,
  output logic          rls_irq_o
);
  rx_ent_t in_ent, head;
  logic    not_empty, push, pop, ovr, err_any;

  assign in_ent = '{brk: rx_brk_i, ferr: rx_ferr_i, perr: rx_perr_i, data: rx_data_i};
  assign rhr_o  = head.data;

  rx_store #(.DEPTH(DEPTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_en_i   (fifo_en_i),
    .wr_i        (rx_valid_i),
    .wdata_i     (in_ent),
    .rd_i        (rhr_rd_i),
    .head_o      (head),
    .not_empty_o (not_empty),
    .push_o      (push),
    .pop_o       (pop),
    .ovr_o       (ovr),
    .err_any_o   (err_any)
  );

  rx_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .head_i      (head),
    .not_empty_i (not_empty),
    .push_i      (push),
    .pop_i       (pop),
    .ovr_i       (ovr),
    .err_any_i   (err_any),
    .lsr_rd_i    (lsr_rd_i),
    .lsr_wr_i    (lsr_wr_i),
    .lsr_wdata_i (lsr_wdata_i),
    .lsr_o       (lsr_o),
    .irq_o       (rls_irq_o)
  );
endmodule

// File: rtl/rx_char_buffer_chk.sv
module rx_char_buffer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fifo_en_i,
  input logic       rx_valid_i,
  input logic       rhr_rd_i,
  input logic       lsr_rd_i,
  input logic       lsr_wr_i,
  input logic [7:0] rhr_o,
  input logic [7:0] lsr_o,
  input logic       rls_irq_o
);
  a_r2_ready_after_arrival: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !rhr_rd_i |=> lsr_o[0]);

  a_r2_ready_needs_arrival: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lsr_o[0]) |-> $past(rx_valid_i));

  a_r4_overrun_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i && lsr_o[0] && rx_valid_i |=> lsr_o[1]);

  a_r4_overrun_keeps_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i && lsr_o[0] && rx_valid_i && !rhr_rd_i |=> $stable(rhr_o) && lsr_o[0]);

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_rd_i && !rx_valid_i && !lsr_wr_i && !rhr_rd_i |=> lsr_o[4:1] == 4'b0000);

  a_r9_irq_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rls_irq_o == (lsr_o[4:1] != 4'b0000));
endmodule

bind rx_char_buffer rx_char_buffer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fifo_en_i  (fifo_en_i),
  .rx_valid_i (rx_valid_i),
  .rhr_rd_i   (rhr_rd_i),
  .lsr_rd_i   (lsr_rd_i),
  .lsr_wr_i   (lsr_wr_i),
  .rhr_o      (rhr_o),
  .lsr_o      (lsr_o),
  .rls_irq_o  (rls_irq_o)
);

// File: tb/rx_char_buffer_test.sv
module rx_char_buffer_test;
  localparam int DEPTH = 16;
  localparam int NV = 19;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fifo_en_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_perr_i = 1'b0, rx_ferr_i = 1'b0, rx_brk_i = 1'b0;
  logic       rhr_rd_i = 1'b0, lsr_rd_i = 1'b0, lsr_wr_i = 1'b0;
  logic [7:0] lsr_wdata_i = '0;
  logic [7:0] rhr_o, lsr_o;
  logic       rls_irq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  rx_char_buffer #(.DEPTH(DEPTH)) uut (.*);

  // {fifo_en, valid, data, perr, ferr, brk, rhr_rd, lsr_rd, exp_lsr, exp_rhr}
  localparam logic [30:0] VEC [NV] = '{
    {1'b1,1'b1,8'h11,1'b0,1'b0,1'b0,1'b0,1'b0,8'h61,8'h11},
    {1'b1,1'b1,8'h22,1'b1,1'b0,1'b0,1'b0,1'b0,8'hE1,8'h11},
    {1'b1,1'b1,8'h33,1'b0,1'b1,1'b0,1'b0,1'b0,8'hE1,8'h11},
    {1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,8'hE5,8'h22},
    {1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,8'hE1,8'h22},
    {1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,8'hE9,8'h33},
    {1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,8'hE0,8'h00},
    {1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,8'h60,8'h00},
    {1'b1,1'b1,8'h44,1'b0,1'b0,1'b1,1'b0,1'b0,8'hF1,8'h44},
    {1'b1,1'b1,8'h55,1'b0,1'b0,1'b0,1'b1,1'b0,8'hE1,8'h55},
    {1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,8'h61,8'h55},
    {1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,8'h60,8'h00},
    {1'b0,1'b1,8'h66,1'b0,1'b0,1'b0,1'b0,1'b0,8'h61,8'h66},
    {1'b0,1'b1,8'h77,1'b0,1'b0,1'b0,1'b0,1'b0,8'h63,8'h66},
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,8'h62,8'h00},
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,8'h60,8'h00},
    {1'b0,1'b1,8'h88,1'b1,1'b0,1'b0,1'b0,1'b0,8'hE5,8'h88},
    {1'b0,1'b1,8'h99,1'b0,1'b0,1'b0,1'b1,1'b0,8'hE2,8'h00},
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,8'h60,8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // inputs applied at a falling edge, one rising edge, outputs read at next falling edge
  task automatic step(input logic fe, input logic v, input logic [7:0] d, input logic p,
                      input logic f, input logic b, input logic rr, input logic lr);
    fifo_en_i = fe; rx_valid_i = v; rx_data_i = d;
    rx_perr_i = p; rx_ferr_i = f; rx_brk_i = b;
    rhr_rd_i = rr; lsr_rd_i = lr;
    @(posedge clk_i);
    @(negedge clk_i);
    rx_valid_i = 1'b0; rhr_rd_i = 1'b0; lsr_rd_i = 1'b0; lsr_wr_i = 1'b0;
  endtask

  task automatic test_write(input logic [7:0] wd);
    lsr_wr_i = 1'b1; lsr_wdata_i = wd;
    @(posedge clk_i);
    @(negedge clk_i);
    lsr_wr_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 lsr at reset", lsr_o, 8'h60);
    chk("R1 irq at reset", {7'b0, rls_irq_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8 idle bits", lsr_o & 8'h60, 8'h60);

    // table: R2 order, R4 overrun, R5 head flags, R6 read clear, R7 summary bit
    for (int i = 0; i < NV; i++) begin
      logic [30:0] e;
      e = VEC[i];
      step(e[30], e[29], e[28:21], e[20], e[19], e[18], e[17], e[16]);
      chk($sformatf("R2 R4 R5 R6 R7 lsr step %0d", i), lsr_o, e[15:8]);
      chk($sformatf("R9 irq step %0d", i), {7'b0, rls_irq_o}, {7'b0, |e[12:9]});
      if (e[8]) chk($sformatf("R2 rhr step %0d", i), rhr_o, e[7:0]);
    end

    // R3 full queue of DEPTH, then R4 overrun on the extra character
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, 1'b1, 8'(i * 7 + 3), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3 full queue no overrun", lsr_o, 8'h61);
    step(1'b1, 1'b1, 8'hEE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 overrun when full", lsr_o, 8'h63);
    for (int i = 0; i < DEPTH; i++) begin
      chk($sformatf("R3 drain order %0d", i), rhr_o, 8'(i * 7 + 3));
      step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    end
    chk("R2 R4 empty after drain, overrun kept", lsr_o, 8'h62);
    step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 clear after drain", lsr_o, 8'h60);

    // R6 overrun collides with status read: overrun wins
    step(1'b0, 1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 8'hA2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 overrun beats read", lsr_o, 8'h63);
    chk("R4 slot keeps first char", rhr_o, 8'hA1);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6 cleared", lsr_o, 8'h60);

    // R10 test write
    test_write(8'h1E);
    chk("R10 forced bits", lsr_o, 8'h7E);
    chk("R10 R9 irq on forced bits", {7'b0, rls_irq_o}, 8'h01);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 read clears forced bits", lsr_o, 8'h60);
    test_write(8'hE1);
    chk("R10 R8 bits 0 5 6 7 ignore write", lsr_o, 8'h60);
    chk("R9 irq low", {7'b0, rls_irq_o}, 8'h00);

    // R1 reset mid-run empties the queue
    step(1'b1, 1'b1, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 lsr after reset", lsr_o, 8'h60);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule